// File: doc/BRIEF.md
# Iterative Multiply-Divide Unit with HI/LO Result Registers

This unit performs 32-bit integer multiplication and division for a processor core, one bit per clock. It writes its results into two private result registers, HI and LO, which are not part of the general register file. A multiply leaves the upper half of the 64-bit product in HI and the lower half in LO. A divide leaves the remainder in HI and the quotient in LO, so that dividend = quotient × divisor + remainder. An input bit chooses between the two's-complement and the unsigned form of each operation.

The core starts an operation with a one-cycle command that carries two operands. The unit then raises `busy` for a fixed 32 cycles while it runs a shift-and-add or restoring shift-subtract loop on the operand magnitudes. It corrects the result signs in the final step. Two read commands return the current HI or LO contents on a one-cycle response strobe; these commands use no operands. A read that arrives during an operation is held back and answered with the fresh result. An arithmetic command that arrives during an operation is dropped. Division by zero completes in the normal time and leaves a defined result.

Top module: `muldiv_hilo`

## Requirements
- R1: After reset, `busy` and `rd_valid` are low, and HI and LO both read as zero.
- R2: A command with `cmd_op` = 2'b00 and `cmd_signed` = 0 leaves the unsigned 64-bit product of `cmd_a` and `cmd_b` in {HI, LO}, with bits 63:32 in HI.
- R3: A command with `cmd_op` = 2'b00 and `cmd_signed` = 1 leaves the two's-complement 64-bit product in {HI, LO}, including for operands of 0x80000000.
- R4: A command with `cmd_op` = 2'b01 and `cmd_signed` = 0 and a nonzero `cmd_b` leaves `cmd_a / cmd_b` in LO and `cmd_a % cmd_b` in HI, both unsigned.
- R5: A command with `cmd_op` = 2'b01 and `cmd_signed` = 1 and a nonzero `cmd_b` gives a quotient truncated toward zero and a remainder that carries the sign of the dividend. The case 0x80000000 / −1 gives LO = 0x80000000 and HI = 0.
- R6: A divide with `cmd_b` = 0, in either form, sets LO to 0xFFFFFFFF and HI to `cmd_a`, and takes the same number of cycles as any other divide.
- R7: After the clock edge that accepts a multiply or divide, `busy` is high for exactly 32 cycles. HI and LO take their new values on the edge where `busy` falls.
- R8: A read command with `cmd_op` = 2'b10 (HI) or 2'b11 (LO), issued while the unit is idle, raises `rd_valid` for one cycle in the next cycle, with the selected register on `rd_data`. `cmd_a`, `cmd_b` and `cmd_signed` have no effect on a read.
- R9: A read command issued while `busy` is high is stalled. `rd_valid` rises on the edge where `busy` falls, and `rd_data` carries the newly written HI or LO.
- R10: A multiply or divide command issued while `busy` is high is ignored. It changes neither the running operation's duration nor its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 2 | 00 multiply, 01 divide, 10 read HI, 11 read LO |
| cmd_signed | input | 1 | 1 selects the two's-complement form of multiply and divide |
| cmd_a | input | 32 | Multiplicand or dividend |
| cmd_b | input | 32 | Multiplier or divisor |
| busy | output | 1 | High while an operation is in progress |
| rd_valid | output | 1 | One-cycle strobe marking a read response |
| rd_data | output | 32 | Value of the register that was read |

## Verification
The hardest situations to reach are the collisions between a running operation and new traffic. These are a read that arrives in the very last busy cycle, which must still return the new result, and a second arithmetic command that must leave no trace. The stimulus follows the reference model's remaining-cycle count. It issues reads and commands at chosen points inside the 32-cycle window, including the final one. The sign corner cases are applied as directed operand pairs around random operands: 0x80000000 paired with itself, with −1 and with 1, and a divisor of zero in both forms. The bench then compares every output on every clock against its behavioural 64-bit model.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
    typedef enum logic [1:0] {
        OP_MUL  = 2'b00,
        OP_DIV  = 2'b01,
        OP_RDHI = 2'b10,
        OP_RDLO = 2'b11
    } md_op_e;
endpackage

// File: rtl/muldiv_mag.sv
// Converts both operands to magnitudes and reports their signs.
module muldiv_mag #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sgn_i,
    output logic [W-1:0] mag_a_o,
    output logic [W-1:0] mag_b_o,
    output logic         neg_a_o,
    output logic         neg_b_o
);
    assign neg_a_o = sgn_i & a_i[W-1];
    assign neg_b_o = sgn_i & b_i[W-1];
    assign mag_a_o = neg_a_o ? (~a_i + 1'b1) : a_i;
    assign mag_b_o = neg_b_o ? (~b_i + 1'b1) : b_i;
endmodule

// File: rtl/mul_step.sv
// One shift-and-add iteration: acc = {partial_upper, multiplier_remaining}.
module mul_step #(
    parameter int W = 32
) (
    input  logic [2*W-1:0] acc_i,
    input  logic [W-1:0]   mcand_i,
    output logic [2*W-1:0] acc_o
);
    logic [W:0] sum;
    assign sum   = {1'b0, acc_i[2*W-1:W]} + (acc_i[0] ? {1'b0, mcand_i} : {(W+1){1'b0}});
    assign acc_o = {sum, acc_i[W-1:1]};
endmodule

// File: rtl/div_step.sv
// One restoring shift-subtract iteration: acc = {remainder, dividend/quotient}.
module div_step #(
    parameter int W = 32
) (
    input  logic [2*W-1:0] acc_i,
    input  logic [W-1:0]   dvsr_i,
    output logic [2*W-1:0] acc_o
);
    logic [W-1:0] rem;
    logic [W-1:0] quo;
    logic [W:0]   sh;
    logic [W-1:0] diff;
    logic         fits;

    assign rem   = acc_i[2*W-1:W];
    assign quo   = acc_i[W-1:0];
    assign sh    = {rem, quo[W-1]};
    assign fits  = (sh >= {1'b0, dvsr_i});
    assign diff  = sh[W-1:0] - dvsr_i;
    assign acc_o = {(fits ? diff : sh[W-1:0]), quo[W-2:0], fits};
endmodule

// File: rtl/muldiv_hilo.sv
module muldiv_hilo
    import muldiv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cmd_valid,
    input  logic [1:0]   cmd_op,
    input  logic         cmd_signed,
    input  logic [W-1:0] cmd_a,
    input  logic [W-1:0] cmd_b,
    output logic         busy,
    output logic         rd_valid,
    output logic [W-1:0] rd_data
);
    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    typedef struct packed {
        logic           busy;
        logic [CW-1:0]  cnt;
        logic           is_div;
        logic           neg_main;
        logic           neg_rem;
        logic           div0;
        logic [2*W-1:0] acc;
        logic [W-1:0]   opnd;
        logic [W-1:0]   dvd;
        logic [W-1:0]   hi;
        logic [W-1:0]   lo;
        logic           pend;
        logic           pend_lo;
        logic           rv;
        logic [W-1:0]   rd;
    } st_t;

    st_t s_q, s_d;

    logic [W-1:0]   mag_a, mag_b;
    logic           neg_a, neg_b;
    logic [2*W-1:0] mul_acc, div_acc, acc_n, prod;
    logic [W-1:0]   q_fix, r_fix;
    logic           start, rd_req;

    muldiv_mag #(.W(W)) u_mag (
        .a_i(cmd_a), .b_i(cmd_b), .sgn_i(cmd_signed),
        .mag_a_o(mag_a), .mag_b_o(mag_b), .neg_a_o(neg_a), .neg_b_o(neg_b)
    );

    mul_step #(.W(W)) u_mul (.acc_i(s_q.acc), .mcand_i(s_q.opnd), .acc_o(mul_acc));
    div_step #(.W(W)) u_div (.acc_i(s_q.acc), .dvsr_i(s_q.opnd), .acc_o(div_acc));

    assign acc_n = s_q.is_div ? div_acc : mul_acc;
    assign prod  = s_q.neg_main ? (~acc_n + 1'b1) : acc_n;
    assign q_fix = s_q.neg_main ? (~acc_n[W-1:0] + 1'b1) : acc_n[W-1:0];
    assign r_fix = s_q.neg_rem ? (~acc_n[2*W-1:W] + 1'b1) : acc_n[2*W-1:W];

    assign rd_req = cmd_valid && (cmd_op == OP_RDHI || cmd_op == OP_RDLO);
    assign start  = cmd_valid && !s_q.busy && (cmd_op == OP_MUL || cmd_op == OP_DIV);

    always_comb begin
        s_d    = s_q;
        s_d.rv = 1'b0;
        if (!s_q.busy) begin
            if (rd_req) begin
                s_d.rv = 1'b1;
                s_d.rd = (cmd_op == OP_RDLO) ? s_q.lo : s_q.hi;
            end else if (start) begin
                s_d.busy     = 1'b1;
                s_d.cnt      = '0;
                s_d.is_div   = (cmd_op == OP_DIV);
                s_d.dvd      = cmd_a;
                s_d.neg_main = neg_a ^ neg_b;
                if (cmd_op == OP_DIV) begin
                    s_d.acc     = {{W{1'b0}}, mag_a};
                    s_d.opnd    = mag_b;
                    s_d.neg_rem = neg_a;
                    s_d.div0    = (cmd_b == '0);
                end else begin
                    s_d.acc     = {{W{1'b0}}, mag_b};
                    s_d.opnd    = mag_a;
                    s_d.neg_rem = 1'b0;
                    s_d.div0    = 1'b0;
                end
            end
        end else begin
            if (rd_req) begin
                s_d.pend    = 1'b1;
                s_d.pend_lo = (cmd_op == OP_RDLO);
            end
            s_d.acc = acc_n;
            s_d.cnt = s_q.cnt + 1'b1;
            if (s_q.cnt == LAST) begin
                s_d.busy = 1'b0;
                if (!s_q.is_div) begin
                    s_d.hi = prod[2*W-1:W];
                    s_d.lo = prod[W-1:0];
                end else if (s_q.div0) begin
                    s_d.hi = s_q.dvd;
                    s_d.lo = '1;
                end else begin
                    s_d.hi = r_fix;
                    s_d.lo = q_fix;
                end
                if (s_d.pend) begin
                    s_d.rv   = 1'b1;
                    s_d.rd   = s_d.pend_lo ? s_d.lo : s_d.hi;
                    s_d.pend = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy     = s_q.busy;
    assign rd_valid = s_q.rv;
    assign rd_data  = s_q.rd;

    // R7
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && s_q.cnt != LAST) |=> s_q.busy);
    // R7
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && s_q.cnt == LAST) |=> !s_q.busy);
    // R10
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && s_q.cnt != LAST) |=> s_q.cnt == CW'($past(s_q.cnt) + 1'b1));
    // R10
    hilo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && s_q.cnt != LAST) |=> ($stable(s_q.hi) && $stable(s_q.lo)));
    // R9
    rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.rv |-> !s_q.busy);
    // R6
    div0_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && s_q.is_div && s_q.div0 && s_q.cnt == LAST) |=> (s_q.lo == '1));
endmodule

// File: tb/sim_muldiv_hilo.sv
module sim_muldiv_hilo;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'b00;
    logic        cmd_signed = 1'b0;
    logic [31:0] cmd_a = '0, cmd_b = '0;
    logic        busy, rd_valid;
    logic [31:0] rd_data;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    string cur_tag = "R1";

    // behavioural reference state
    int          cnt_m = 0;
    logic [31:0] hi_m = '0, lo_m = '0, rh = '0, rl = '0, rd_m = '0;
    bit          rv_m = 0, pend_m = 0, plo_m = 0;

    always #10 clk = ~clk;

    muldiv_hilo #(.W(32)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_signed(cmd_signed), .cmd_a(cmd_a), .cmd_b(cmd_b),
        .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    task automatic ref_calc(input bit is_div, input bit sgn, input logic [31:0] a, input logic [31:0] b);
        longint sa, sb, p, q, r;
        logic [63:0] up;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        if (!is_div) begin
            if (sgn) begin p = sa * sb; {rh, rl} = p; end
            else begin up = {32'h0, a} * {32'h0, b}; {rh, rl} = up; end
        end else if (b == 0) begin
            rl = 32'hFFFF_FFFF; rh = a;
        end else if (sgn) begin
            q = sa / sb; r = sa % sb;
            rl = q[31:0]; rh = r[31:0];
        end else begin
            rl = a / b; rh = a % b;
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            cnt_m = 0; hi_m = '0; lo_m = '0; rv_m = 0; pend_m = 0; rd_m = '0;
        end else begin
            rv_m = 0;
            if (cnt_m > 0) begin
                if (cmd_valid && cmd_op[1]) begin pend_m = 1; plo_m = cmd_op[0]; end
                cnt_m--;
                if (cnt_m == 0) begin
                    hi_m = rh; lo_m = rl;
                    if (pend_m) begin rv_m = 1; rd_m = plo_m ? lo_m : hi_m; pend_m = 0; end
                end
            end else if (cmd_valid) begin
                if (cmd_op[1]) begin rv_m = 1; rd_m = cmd_op[0] ? lo_m : hi_m; end
                else begin ref_calc(cmd_op[0], cmd_signed, cmd_a, cmd_b); cnt_m = 32; end
            end
        end
    end

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            check("R7", "busy", {31'b0, busy}, {31'b0, cnt_m > 0});
            check("R8", "rd_valid", {31'b0, rd_valid}, {31'b0, rv_m});
            if (rv_m) check(cur_tag, "rd_data", rd_data, rd_m);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL R7 watchdog: actual=%0d expected=%0d", cyc, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic cmd(input logic [1:0] op, input bit sgn, input logic [31:0] a, input logic [31:0] b);
        cmd_valid = 1; cmd_op = op; cmd_signed = sgn; cmd_a = a; cmd_b = b;
        @(negedge clk);
        cmd_valid = 0; cmd_a = $urandom; cmd_b = $urandom;
    endtask

    task automatic wait_idle();
        while (cnt_m > 0) @(negedge clk);
    endtask

    task automatic run_op(input string tag, input logic [1:0] op, input bit sgn, input logic [31:0] a, input logic [31:0] b);
        cur_tag = tag;
        cmd(op, sgn, a, b);
        wait_idle();
        cmd(2'b10, $urandom, $urandom, $urandom);
        cmd(2'b11, $urandom, $urandom, $urandom);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        check("R1", "busy", {31'b0, busy}, 32'd0);
        check("R1", "rd_valid", {31'b0, rd_valid}, 32'd0);
        cur_tag = "R1";
        cmd(2'b10, 0, 0, 0);
        check("R1", "HI", rd_data, 32'd0);
        cmd(2'b11, 1, 32'hFFFF_FFFF, 1);
        check("R1", "LO", rd_data, 32'd0);
        @(negedge clk);

        // R2 unsigned multiply
        run_op("R2", 2'b00, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        run_op("R2", 2'b00, 0, 32'h0, 32'h1234_5678);
        for (int i = 0; i < 8; i++) run_op("R2", 2'b00, 0, $urandom, $urandom);
        // R3 signed multiply
        run_op("R3", 2'b00, 1, 32'h8000_0000, 32'h8000_0000);
        run_op("R3", 2'b00, 1, 32'h8000_0000, 32'hFFFF_FFFF);
        run_op("R3", 2'b00, 1, 32'hFFFF_FFFF, 32'd5);
        for (int i = 0; i < 8; i++) run_op("R3", 2'b00, 1, $urandom, $urandom);
        // R4 unsigned divide
        run_op("R4", 2'b01, 0, 32'd7, 32'd9);
        run_op("R4", 2'b01, 0, 32'hFFFF_FFFF, 32'd1);
        run_op("R4", 2'b01, 0, 32'h8000_0000, 32'hFFFF_FFFF);
        for (int i = 0; i < 8; i++) run_op("R4", 2'b01, 0, $urandom, ($urandom >> (i * 3)) | 32'd1);
        // R5 signed divide
        run_op("R5", 2'b01, 1, -32'sd7, 32'd2);
        run_op("R5", 2'b01, 1, 32'd7, -32'sd2);
        run_op("R5", 2'b01, 1, 32'h8000_0000, 32'hFFFF_FFFF);
        run_op("R5", 2'b01, 1, 32'h8000_0000, 32'd1);
        for (int i = 0; i < 8; i++) run_op("R5", 2'b01, 1, $urandom, ($urandom >> (i * 3)) | 32'd1);
        // R6 divide by zero
        run_op("R6", 2'b01, 0, 32'hDEAD_BEEF, 32'd0);
        run_op("R6", 2'b01, 1, 32'h8000_0001, 32'd0);
        run_op("R6", 2'b01, 1, 32'd0, 32'd0);
        // R8: operands of a read do not matter
        cur_tag = "R8";
        cmd(2'b11, 1, 32'h5555_5555, 32'hAAAA_AAAA);
        cmd(2'b10, 0, 32'h1, 32'h0);
        @(negedge clk);
        // R9: read early in the window and in the last busy cycle
        cur_tag = "R9";
        cmd(2'b00, 1, 32'h1234_5678, 32'h9ABC_DEF0);
        repeat (4) @(negedge clk);
        cmd(2'b11, 0, 0, 0);
        wait_idle();
        @(negedge clk);
        cmd(2'b01, 0, 32'hF000_0000, 32'd3);
        while (cnt_m != 1) @(negedge clk);
        cmd(2'b10, 0, 0, 0);
        @(negedge clk);
        // R10: arithmetic commands during busy are dropped
        cur_tag = "R10";
        cmd(2'b00, 0, 32'd1000, 32'd3000);
        @(negedge clk);
        cmd(2'b01, 0, 32'd99, 32'd0);
        while (cnt_m != 1) @(negedge clk);
        cmd(2'b00, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        wait_idle();
        cmd(2'b10, 0, 0, 0);
        check("R10", "HI", rd_data, 32'd0);
        cmd(2'b11, 0, 0, 0);
        check("R10", "LO", rd_data, 32'd3_000_000);
        repeat (2) @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule